// File: doc/BRIEF.md
# Multi-Writer FIFO Write Arbiter

Several producers share the write port of one FIFO through this block. Each producer presents an 8-bit record and a request bit. The arbiter picks one pending producer in each cycle and drives the FIFO's write enable and data bus with that producer's record. It raises a busy line to every other pending producer. A producer that sees busy must hold its request and its record unchanged until it sees busy low. The cycle in which a producer sees busy low with its request high is the cycle its record is written.

All records arrive on one packed bus. Producer i uses bits [8i+7:8i]. The selection is round-robin. A registered pointer holds the index of the last producer served. The search starts at the index after it and wraps, so a producer that keeps requesting is never starved. All outputs are combinational from the present requests and the pointer. The FIFO is assumed never to be full.

Top module: `fifo_write_arbiter`

## Requirements
- R1: After reset the pointer stands at the last index, so producer 0 has first priority. With every producer requesting and holding, the producers are served in the order 0, 1, 2, 3.
- R2: `fifo_we` is high in exactly those cycles in which at least one bit of `wr_req` is high.
- R3: In a cycle with a pending request, exactly one requesting producer sees busy low: that is the producer being served. Every other requesting producer sees busy high.
- R4: A producer whose request bit is low always sees its busy bit low.
- R5: While `fifo_we` is high, `fifo_data` equals the record of the served producer, taken from bits [8i+7:8i] of `wr_data`.
- R6: While no request is pending, `fifo_data` is zero.
- R7: The served producer is the first requesting index after the last served index, searching upward and wrapping from N-1 to 0. Cycles with no request leave the pointer unchanged.
- R8: A producer that keeps requesting is served within NUM_WRITERS cycles of raising its request.
- R9: A request that is still high in the cycle after the producer was served counts as a new record. It is written again when selected, with whatever data the producer then shows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_data | input | NUM_WRITERS*8 | Packed records, producer i in bits [8i+7:8i] |
| wr_req | input | NUM_WRITERS | Request bit per producer |
| wr_busy | output | NUM_WRITERS | Stall per producer: hold request and record while high |
| fifo_we | output | 1 | Write enable into the FIFO |
| fifo_data | output | 8 | Record written into the FIFO |

## Verification
Selection and stall coincide in every contended cycle: one producer is written while the others are stalled. In the same cycle, the served producer may also be one that was re-requesting right after its own service. The bench provokes this with random traffic in which stalled producers obey the hold rule. It adds directed runs: all producers request at once after reset, and a single producer keeps its request high across several cycles with fresh data. A behavioural model keeps the last-served index as an integer. On every clock the bench compares the write enable, the data bus, every busy bit and the served index against that model, and it also tracks each producer's waiting time.

// File: rtl/fifo_arb_pkg.sv
package fifo_arb_pkg;
    localparam int REC_W = 8;

    typedef logic [REC_W-1:0] rec_t;

    typedef struct packed {
        logic valid;
        rec_t data;
    } fifo_beat_t;

    // index reached by stepping `step` places past `base`, modulo `n`
    function automatic int wrap_idx(input int base, input int step, input int n);
        return (base + step) % n;
    endfunction
endpackage

// File: rtl/rr_select.sv
module rr_select #(
    parameter int N     = 4,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     req,
    input  logic [IDX_W-1:0] last_idx,
    output logic             any,
    output logic [IDX_W-1:0] win_idx,
    output logic [N-1:0]     win_oh
);
    import fifo_arb_pkg::*;

    always_comb begin
        any     = 1'b0;
        win_idx = '0;
        for (int off = 1; off <= N; off++) begin
            if (!any && req[wrap_idx(int'(last_idx), off, N)]) begin
                any     = 1'b1;
                win_idx = IDX_W'(wrap_idx(int'(last_idx), off, N));
            end
        end
        win_oh = any ? (N'(1) << win_idx) : '0;
    end

    // R3
    always_comb begin
        win_is_requester_chk: assert (!any || req[win_idx]);
    end
endmodule

// File: rtl/rr_pointer.sv
module rr_pointer #(
    parameter int N     = 4,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             any,
    input  logic [IDX_W-1:0] win_idx,
    output logic [IDX_W-1:0] last_idx
);
    always_ff @(posedge clk) begin
        if (rst)
            last_idx <= IDX_W'(N - 1);
        else if (any)
            last_idx <= win_idx;
    end

    // R1
    ptr_reset_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> last_idx == IDX_W'(N - 1));
endmodule

// File: rtl/rec_mux.sv
module rec_mux #(
    parameter int N     = 4,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N*fifo_arb_pkg::REC_W-1:0] bus,
    input  logic                             any,
    input  logic [IDX_W-1:0]                 win_idx,
    output fifo_arb_pkg::fifo_beat_t         beat
);
    import fifo_arb_pkg::*;

    rec_t recs [N];

    for (genvar g = 0; g < N; g++) begin : g_unpack
        assign recs[g] = bus[g*REC_W +: REC_W];
    end

    always_comb begin
        beat.valid = any;
        beat.data  = any ? recs[win_idx] : '0;
    end
endmodule

// File: rtl/fifo_write_arbiter.sv
module fifo_write_arbiter #(
    parameter int NUM_WRITERS = 4,
    localparam int IDX_W      = (NUM_WRITERS > 1) ? $clog2(NUM_WRITERS) : 1,
    localparam int BUS_W      = NUM_WRITERS * fifo_arb_pkg::REC_W
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [BUS_W-1:0]              wr_data,
    input  logic [NUM_WRITERS-1:0]        wr_req,
    output logic [NUM_WRITERS-1:0]        wr_busy,
    output logic                          fifo_we,
    output logic [fifo_arb_pkg::REC_W-1:0] fifo_data
);
    import fifo_arb_pkg::*;

    logic                   any;
    logic [IDX_W-1:0]       win_idx;
    logic [IDX_W-1:0]       last_idx;
    logic [NUM_WRITERS-1:0] win_oh;
    fifo_beat_t             beat;

    rr_select #(.N(NUM_WRITERS), .IDX_W(IDX_W)) u_sel (
        .req(wr_req), .last_idx(last_idx),
        .any(any), .win_idx(win_idx), .win_oh(win_oh)
    );

    rr_pointer #(.N(NUM_WRITERS), .IDX_W(IDX_W)) u_ptr (
        .clk(clk), .rst(rst), .any(any), .win_idx(win_idx), .last_idx(last_idx)
    );

    rec_mux #(.N(NUM_WRITERS), .IDX_W(IDX_W)) u_mux (
        .bus(wr_data), .any(any), .win_idx(win_idx), .beat(beat)
    );

    assign wr_busy   = wr_req & ~win_oh;
    assign fifo_we   = beat.valid;
    assign fifo_data = beat.data;

    // R3
    single_winner_chk: assert property (@(posedge clk) disable iff (rst)
        (|wr_req) |-> $countones(wr_req & ~wr_busy) == 1);

    // R4
    idle_not_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_busy & ~wr_req) == '0);

    // R2
    we_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        fifo_we == (wr_req != '0));

    // R6
    idle_data_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !fifo_we |-> fifo_data == '0);
endmodule

// File: tb/tb_fifo_write_arbiter.sv
module tb_fifo_write_arbiter;
    localparam int CLK_PERIOD = 10;
    localparam int N          = 4;
    localparam int WATCHDOG   = 20000;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [N*8-1:0] wr_data;
    logic [N-1:0]   wr_req;
    logic [N-1:0]   wr_busy;
    logic           fifo_we;
    logic [7:0]     fifo_data;

    logic [7:0] d [N];
    int  last_served;   // model pointer
    int  waited [N];
    int  n_checks = 0;
    int  n_fail   = 0;
    int  cycles   = 0;
    bit  done     = 0;

    fifo_write_arbiter #(.NUM_WRITERS(N)) dut (
        .clk(clk), .rst(rst), .wr_data(wr_data), .wr_req(wr_req),
        .wr_busy(wr_busy), .fifo_we(fifo_we), .fifo_data(fifo_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always_comb
        for (int i = 0; i < N; i++) wr_data[i*8 +: 8] = d[i];

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int model_winner();
        for (int off = 1; off <= N; off++)
            if (wr_req[(last_served + off) % N]) return (last_served + off) % N;
        return -1;
    endfunction

    // full per-cycle comparison against the model; returns served index
    task automatic compare(output int w);
        w = model_winner();
        chk("R2 we", int'(fifo_we), int'(w >= 0));
        for (int i = 0; i < N; i++) begin
            if (!wr_req[i]) chk("R4 busy idle", int'(wr_busy[i]), 0);
            else            chk("R3/R7 busy", int'(wr_busy[i]), int'(i != w));
        end
        if (w >= 0) chk("R5 data", int'(fifo_data), int'(d[w]));
        else        chk("R6 data zero", int'(fifo_data), 0);
        for (int i = 0; i < N; i++) begin
            if (wr_req[i] && i != w) begin
                waited[i]++;
                chk("R8 starvation", int'(waited[i] < N), 1);
            end else waited[i] = 0;
        end
    endtask

    task automatic step_edge(input int w);
        @(posedge clk);
        if (w >= 0) last_served = w;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        wr_req = '0;
        for (int i = 0; i < N; i++) begin d[i] = '0; waited[i] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        last_served = N - 1;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        int w;
        logic [N-1:0] prev_busy;
        do_reset();
        #2;
        chk("R1 reset we", int'(fifo_we), 0);
        chk("R1 reset busy", int'(wr_busy), 0);

        // R1: all request after reset, served 0,1,2,3 in order
        @(negedge clk);
        wr_req = '1;
        for (int i = 0; i < N; i++) d[i] = 8'(8'h10 + i);
        for (int k = 0; k < N; k++) begin
            #2;
            compare(w);
            chk("R1 order", w, k);
            chk("R1 busy low on served", int'(wr_busy[k]), 0);
            step_edge(w);
            @(negedge clk);
            wr_req[k] = 1'b0;
        end
        #2; compare(w);
        chk("R2 idle after drain", int'(fifo_we), 0);
        step_edge(w);

        // R9: one producer holds request with fresh data each cycle
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            wr_req = 4'b0100;
            d[2] = 8'(8'hA0 + k);
            #2; compare(w);
            chk("R9 rewrite data", int'(fifo_data), 8'hA0 + k);
            chk("R9 we", int'(fifo_we), 1);
            step_edge(w);
        end

        // R7 wrap: last served is 2; producers 1 and 3 request -> 3 then 1
        @(negedge clk);
        wr_req = 4'b1010; d[1] = 8'h55; d[3] = 8'h77;
        #2; compare(w); chk("R7 wrap first", w, 3); step_edge(w);
        @(negedge clk); wr_req[3] = 1'b0;
        #2; compare(w); chk("R7 wrap second", w, 1); step_edge(w);
        @(negedge clk); wr_req = '0;
        #2; compare(w); step_edge(w);
        // R7 idle cycle leaves pointer: next pick after 1 is 2
        @(negedge clk); wr_req = 4'b0101; d[0] = 8'h01; d[2] = 8'h02;
        #2; compare(w); chk("R7 pointer kept over idle", w, 2); step_edge(w);
        @(negedge clk); wr_req = '0;
        #2; compare(w); step_edge(w);

        // random traffic obeying the hold rule
        prev_busy = '0;
        for (int c = 0; c < 3000; c++) begin
            @(negedge clk);
            for (int i = 0; i < N; i++) begin
                if (!(wr_req[i] && prev_busy[i])) begin
                    wr_req[i] = ($urandom_range(0, 99) < 60);
                    d[i] = 8'($urandom);
                end
            end
            #2;
            compare(w);
            prev_busy = wr_busy;
            step_edge(w);
        end

        // reset mid-stream returns priority to producer 0
        do_reset();
        wr_req = 4'b1001; d[0] = 8'hC0; d[3] = 8'hC3;
        #2; compare(w); chk("R1 priority after reset", w, 0); step_edge(w);

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule